// File: doc/BRIEF.md
# NAND Access Width Adapter

This block sits between a processor register port and a NAND flash cycle port. A processor access of one, two or four bytes arrives with a window code and a size code. The block turns it into the right number of NAND bus cycles for a device that is either 8 or 16 bits wide. Write data goes out least significant part first. For reads, the returned NAND cycles are packed into one 32-bit word in the same order.

The window code picks how each cycle is marked. Command-window cycles raise the command latch, address-window cycles raise the address latch, and data-window cycles raise neither. A fourth window stands for the ordinary control registers next to the NAND windows. The block only checks the access width there: those registers take full 32-bit accesses only, and a narrower access is flagged. When the chip select is not set up as a NAND device, the NAND windows finish without touching the bus.

The processor holds `cpu_req` with stable fields until it sees a one-cycle `cpu_ready`, then drops the request. Each NAND cycle is offered on `nd_strobe` and stays unchanged until the device answers with `nd_ack`.

Top module: `nand_width_adapter`

## Requirements
- R1: With `cfg_wide`=0, size code 0 (1 byte) makes one NAND cycle, code 1 (2 bytes) makes two, and codes 2 and 3 (4 bytes) make four. Cycle k carries `cpu_wdata[8k+7:8k]` on `nd_wdata[7:0]` with `nd_wdata[15:8]`=0.
- R2: With `cfg_wide`=1, size code 1 makes one NAND cycle and codes 2 and 3 make two. Cycle k carries `cpu_wdata[16k+15:16k]`, so the low halfword goes first.
- R3: A 1-byte read (size code 0) from a 16-bit device makes one cycle and returns `nd_rdata[7:0]` zero-extended to 32 bits.
- R4: A 1-byte write to a 16-bit device makes one cycle carrying `cpu_wdata[15:0]`.
- R5: Window code 0 (command) drives `nd_cle`=1 and `nd_ale`=0 on every cycle. Code 1 (address) drives `nd_ale`=1 and `nd_cle`=0. Code 2 (data) drives both low. `nd_cle` and `nd_ale` are never high together. `nd_we` equals `cpu_we` on every cycle.
- R6: A data-window read packs its cycles into `cpu_rdata`, earliest cycle in the least significant position: bytes for an 8-bit device, halfwords for a 16-bit device. Bits above the access size read 0.
- R7: Window code 3 (control registers) makes no NAND cycle and returns `cpu_rdata`=0. `cpu_err` is high together with `cpu_ready` when the size code is 0 or 1, and low when it is 2 or 3.
- R8: With `cfg_nand`=0, accesses to windows 0 to 2 make no NAND cycle, return `cpu_rdata`=0 and raise no error.
- R9: `cpu_ready` is high for exactly one cycle, the cycle after the `nd_ack` of the last NAND cycle, or the cycle after the request is taken when no NAND cycle is needed. While `nd_strobe` waits for `nd_ack`, the cycle's data and control outputs hold steady.
- R10: A read of the command or address window makes no NAND cycle and returns 0.
- R11: After reset, `cpu_ready`, `cpu_err`, `nd_strobe` and `cpu_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_nand | input | 1 | Chip select is set up as a NAND device |
| cfg_wide | input | 1 | Device is 16 bits wide (0: 8 bits) |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_win | input | 2 | Window: 0 command, 1 address, 2 data, 3 control registers |
| cpu_size | input | 2 | Size: 0 byte, 1 halfword, 2 or 3 word |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_err | output | 1 | Width error, valid with `cpu_ready` |
| nd_strobe | output | 1 | NAND cycle offered |
| nd_ack | input | 1 | NAND cycle accepted |
| nd_cle | output | 1 | Command latch enable for this cycle |
| nd_ale | output | 1 | Address latch enable for this cycle |
| nd_we | output | 1 | Cycle direction, 1 for write |
| nd_wdata | output | 16 | Write data for this cycle |
| nd_rdata | input | 16 | Read data returned with `nd_ack` |

## Verification
The bench runs every combination of device type, device width, window, direction and size code, with a different write word for each access. Size codes 2 and 3 are both run, which checks that the two word codes give the same result. Because a single word is split as bytes on the narrow device and as halfwords on the wide one, any lane-order or cycle-count mistake shows up. The device model answers each strobe after one wait cycle and returns a different value for each cycle. A packed read word therefore exposes swapped positions and stale lanes. Running the command and address windows in both directions, plus the register window at every size, separates the marking, suppression and width-error paths from one another.

// File: rtl/nwa_pkg.sv
// Shared types of the NAND access width adapter.
// Assumes the window and size codes listed in the brief.
package nwa_pkg;
    typedef enum logic [1:0] {
        WIN_CMD  = 2'd0,
        WIN_ADDR = 2'd1,
        WIN_DATA = 2'd2,
        WIN_REG  = 2'd3
    } win_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_DONE = 2'd2
    } seq_st_e;

    // Per-access control fields captured when a request is taken.
    typedef struct packed {
        logic we;
        logic cle;
        logic ale;
        logic err;
        logic wide;
        logic [1:0] size;
    } acc_ctl_t;
endpackage

// File: rtl/nwa_plan.sv
// Access planner: decodes a live request into its cycle count, marking
// and error flag. Purely combinational. Assumes size codes 2 and 3 both
// mean a full word.
module nwa_plan
    import nwa_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              cfg_nand,
    input  logic              cfg_wide,
    input  logic              we,
    input  logic [1:0]        win,
    input  logic [1:0]        size,
    output logic              bypass,
    output logic              err,
    output logic              cle,
    output logic              ale,
    output logic [BEAT_W-1:0] last_beat
);
    logic [2:0] nbytes;
    logic [2:0] nlast;

    // Byte count of the access from its size code.
    always_comb begin
        case (size)
            SZ_BYTE: nbytes = 3'd1;
            SZ_HALF: nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
    end

    // Index of the last cycle: bytes on a narrow device, halfwords on a wide one.
    always_comb begin
        if (cfg_wide) begin
            nlast = (nbytes[2:1] == 2'd0) ? 3'd0 : ({1'b0, nbytes[2:1]} - 3'd1);
        end else begin
            nlast = nbytes - 3'd1;
        end
    end

    assign last_beat = nlast[BEAT_W-1:0];

    // Requests that complete without any NAND cycle.
    assign bypass = (win == WIN_REG) || !cfg_nand ||
                    (!we && (win != WIN_DATA));
    assign err    = (win == WIN_REG) && (size == SZ_BYTE || size == SZ_HALF);
    assign cle    = (win == WIN_CMD);
    assign ale    = (win == WIN_ADDR);
endmodule

// File: rtl/nwa_seq.sv
// Cycle sequencer: takes a request, steps a beat counter through the NAND
// cycles with a strobe/ack handshake, then pulses ready for one cycle.
// Assumes the requester drops its request after seeing ready.
module nwa_seq
    import nwa_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              bypass,
    input  logic [BEAT_W-1:0] last_beat,
    input  logic              ack,
    output logic              start,
    output logic              strobe,
    output logic              ready,
    output logic              cap,
    output logic [BEAT_W-1:0] beat
);
    seq_st_e st_q;
    logic [BEAT_W-1:0] beat_q;

    // State and beat counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            beat_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req) begin
                        beat_q <= '0;
                        st_q   <= bypass ? ST_DONE : ST_BUS;
                    end
                end
                ST_BUS: begin
                    if (ack) begin
                        if (beat_q == last_beat) begin
                            st_q <= ST_DONE;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign start  = (st_q == ST_IDLE) && req;
    assign strobe = (st_q == ST_BUS);
    assign ready  = (st_q == ST_DONE);
    assign cap    = strobe && ack;
    assign beat   = beat_q;

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R9
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !ack) |=> (strobe && $stable(beat)));

    // R9
    ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && ack && beat == last_beat) |=> ready);

    // R1
    beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (beat <= last_beat));
endmodule

// File: rtl/nwa_pack.sv
// Data path: picks the write lane for the current beat and gathers read
// beats into byte lanes. Assumes an 8-bit lane is the narrow device width.
module nwa_pack #(
    parameter int CPU_W  = 32,
    parameter int BUS_W  = 16,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic              we,
    input  logic              wide,
    input  logic [1:0]        size,
    input  logic              ready,
    input  logic [BEAT_W-1:0] beat,
    input  logic [CPU_W-1:0]  cpu_wdata,
    input  logic [BUS_W-1:0]  nd_rdata,
    output logic [BUS_W-1:0]  nd_wdata,
    output logic [CPU_W-1:0]  rdata
);
    localparam int LANE_W    = BUS_W / 2;
    localparam int CPU_LANES = CPU_W / LANE_W;

    logic [CPU_W-1:0] wdata_q;
    logic [CPU_W-1:0] acc;
    logic [CPU_W-1:0] wsh_n;
    logic [CPU_W-1:0] wsh_w;
    logic [CPU_W-1:0] mask;

    // Hold the write word for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (clr) begin
            wdata_q <= cpu_wdata;
        end
    end

    // Lane select for the current beat, narrow or wide.
    always_comb begin
        wsh_n = wdata_q >> ({beat, 3'b000});
        wsh_w = wdata_q >> ({beat, 4'b0000});
        if (wide) begin
            nd_wdata = wsh_w[BUS_W-1:0];
        end else begin
            nd_wdata = {{(BUS_W-LANE_W){1'b0}}, wsh_n[LANE_W-1:0]};
        end
    end

    for (genvar i = 0; i < CPU_LANES; i++) begin : g_lane
        logic              hit;
        logic [LANE_W-1:0] src;
        logic [LANE_W-1:0] q;
        assign hit = wide ? (beat == BEAT_W'(i / 2)) : (beat == BEAT_W'(i));
        assign src = wide ? nd_rdata[LANE_W*(i%2) +: LANE_W] : nd_rdata[LANE_W-1:0];
        // Capture this lane from the read beat that maps onto it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (clr) begin
                q <= '0;
            end else if (cap && !we && hit) begin
                q <= src;
            end
        end
        assign acc[LANE_W*i +: LANE_W] = q;
    end

    // Bits beyond the access size are forced to zero.
    always_comb begin
        case (size)
            2'd0:    mask = CPU_W'({LANE_W{1'b1}});
            2'd1:    mask = CPU_W'({BUS_W{1'b1}});
            default: mask = '1;
        endcase
    end

    assign rdata = ready ? (acc & mask) : '0;
endmodule

// File: rtl/nand_width_adapter.sv
// Top of the NAND access width adapter: plans each processor access,
// sequences the NAND cycles and packs read data. Assumes configuration
// inputs are steady while an access is in flight.
module nand_width_adapter
    import nwa_pkg::*;
#(
    parameter int CPU_W = 32,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_nand,
    input  logic             cfg_wide,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [1:0]       cpu_win,
    input  logic [1:0]       cpu_size,
    input  logic [CPU_W-1:0] cpu_wdata,
    output logic             cpu_ready,
    output logic [CPU_W-1:0] cpu_rdata,
    output logic             cpu_err,
    output logic             nd_strobe,
    input  logic             nd_ack,
    output logic             nd_cle,
    output logic             nd_ale,
    output logic             nd_we,
    output logic [BUS_W-1:0] nd_wdata,
    input  logic [BUS_W-1:0] nd_rdata
);
    localparam int CPU_BYTES = CPU_W / 8;
    localparam int BEAT_W    = $clog2(CPU_BYTES);

    logic              p_bypass;
    logic              p_err;
    logic              p_cle;
    logic              p_ale;
    logic [BEAT_W-1:0] p_last;
    logic [BEAT_W-1:0] last_q;
    acc_ctl_t          ctl_q;
    logic              start;
    logic              strobe;
    logic              ready;
    logic              cap;
    logic [BEAT_W-1:0] beat;

    nwa_plan #(.BEAT_W(BEAT_W)) plan_i (
        .cfg_nand  (cfg_nand),
        .cfg_wide  (cfg_wide),
        .we        (cpu_we),
        .win       (cpu_win),
        .size      (cpu_size),
        .bypass    (p_bypass),
        .err       (p_err),
        .cle       (p_cle),
        .ale       (p_ale),
        .last_beat (p_last)
    );

    // Capture the planned controls when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            last_q <= '0;
        end else if (start) begin
            ctl_q.we   <= cpu_we;
            ctl_q.cle  <= p_cle;
            ctl_q.ale  <= p_ale;
            ctl_q.err  <= p_err;
            ctl_q.wide <= cfg_wide;
            ctl_q.size <= cpu_size;
            last_q     <= p_last;
        end
    end

    nwa_seq #(.BEAT_W(BEAT_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cpu_req),
        .bypass    (p_bypass),
        .last_beat (last_q),
        .ack       (nd_ack),
        .start     (start),
        .strobe    (strobe),
        .ready     (ready),
        .cap       (cap),
        .beat      (beat)
    );

    nwa_pack #(.CPU_W(CPU_W), .BUS_W(BUS_W), .BEAT_W(BEAT_W)) pack_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .cap       (cap),
        .we        (ctl_q.we),
        .wide      (ctl_q.wide),
        .size      (ctl_q.size),
        .ready     (ready),
        .beat      (beat),
        .cpu_wdata (cpu_wdata),
        .nd_rdata  (nd_rdata),
        .nd_wdata  (nd_wdata),
        .rdata     (cpu_rdata)
    );

    assign nd_strobe = strobe;
    assign nd_cle    = strobe && ctl_q.cle;
    assign nd_ale    = strobe && ctl_q.ale;
    assign nd_we     = strobe && ctl_q.we;
    assign cpu_ready = ready;
    assign cpu_err   = ready && ctl_q.err;

    // R5
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nd_cle && nd_ale));

    // R7
    err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> cpu_ready);

    // R10
    marked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nd_strobe && (nd_cle || nd_ale)) |-> nd_we);

    // R9
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nd_strobe && !nd_ack) |=> ($stable(nd_wdata) && $stable(nd_cle) &&
                                    $stable(nd_ale) && $stable(nd_we)));

    // R1
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nd_strobe && !ctl_q.wide) |-> (nd_wdata[BUS_W-1:BUS_W/2] == '0));
endmodule

// File: tb/nand_width_adapter_tb.sv
// Sweep bench: every device type, width, window, direction and size code.
module nand_width_adapter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_nand = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_win = 2'd0;
    logic [1:0]  cpu_size = 2'd0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        cpu_err;
    logic        nd_strobe;
    logic        nd_ack = 1'b0;
    logic        nd_cle;
    logic        nd_ale;
    logic        nd_we;
    logic [15:0] nd_wdata;
    logic [15:0] nd_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [15:0] lg_wd [8];
    logic        lg_cle [8];
    logic        lg_ale [8];
    logic        lg_we [8];
    int          lg_n = 0;

    nand_width_adapter dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_nand (cfg_nand), .cfg_wide (cfg_wide),
        .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_win (cpu_win),
        .cpu_size (cpu_size), .cpu_wdata (cpu_wdata), .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata), .cpu_err (cpu_err), .nd_strobe (nd_strobe),
        .nd_ack (nd_ack), .nd_cle (nd_cle), .nd_ale (nd_ale), .nd_we (nd_we),
        .nd_wdata (nd_wdata), .nd_rdata (nd_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] pat(input int k);
        return 16'(32'h9A10 + k * 32'h1523);
    endfunction

    // Device model: one wait cycle, then ack; logs each accepted cycle.
    always @(negedge clk) begin
        if (nd_strobe && !nd_ack) begin
            if (lg_n < 8) begin
                lg_wd[lg_n]  = nd_wdata;
                lg_cle[lg_n] = nd_cle;
                lg_ale[lg_n] = nd_ale;
                lg_we[lg_n]  = nd_we;
            end
            nd_rdata = pat(lg_n);
            lg_n     = lg_n + 1;
            nd_ack   = 1'b1;
        end else begin
            nd_ack = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic int exp_beats(input bit n, input bit w, input int win,
                                     input bit we, input int sz);
        if (win == 3 || !n || (!we && win != 2)) return 0;
        if (w) return (sz <= 1) ? 1 : 2;
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    task automatic run_access(input bit n, input bit w, input int win,
                              input bit we, input int sz, input logic [31:0] wd);
        int nb;
        int got;
        logic [31:0] rd;
        logic er;
        logic [31:0] exp_rd;
        logic [15:0] exp_wd;
        string tag;
        bit seen;
        @(negedge clk);
        cfg_nand  = n;
        cfg_wide  = w;
        cpu_we    = we;
        cpu_win   = 2'(win);
        cpu_size  = 2'(sz);
        cpu_wdata = wd;
        cpu_req   = 1'b1;
        lg_n      = 0;
        seen      = 1'b0;
        rd        = '0;
        er        = 1'b0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (cpu_ready) begin
                seen = 1'b1;
                got  = lg_n;
                rd   = cpu_rdata;
                er   = cpu_err;
                break;
            end
        end
        cpu_req = 1'b0;
        chk(seen, "R9", 32'(seen), 32'd1);
        if (!seen) return;
        nb = exp_beats(n, w, win, we, sz);
        if (win == 3) tag = "R7";
        else if (!n) tag = "R8";
        else if (!we && win != 2) tag = "R10";
        else if (w && sz == 0) tag = we ? "R4" : "R3";
        else tag = w ? "R2" : "R1";
        // cycle count when ready appears (R9: ready only after the last ack)
        chk(got == nb, tag, 32'(got), 32'(nb));
        if (got == nb) begin
            for (int k = 0; k < nb; k++) begin
                exp_wd = w ? 16'(wd >> (16 * k)) : {8'h00, 8'(wd >> (8 * k))};
                if (we) chk(lg_wd[k] == exp_wd, tag, 32'(lg_wd[k]), 32'(exp_wd));
                chk(lg_cle[k] == (win == 0) && lg_ale[k] == (win == 1), "R5",
                    {30'd0, lg_cle[k], lg_ale[k]}, {30'd0, win == 0, win == 1});
                chk(lg_we[k] == we, "R5", 32'(lg_we[k]), 32'(we));
            end
        end
        exp_rd = '0;
        if (!we && nb > 0) begin
            if (w) begin
                if (sz == 0) exp_rd = {24'd0, pat(0)[7:0]};
                else if (sz == 1) exp_rd = {16'd0, pat(0)};
                else exp_rd = {pat(1), pat(0)};
            end else begin
                for (int k = 0; k < nb; k++) exp_rd = exp_rd | (32'(pat(k)[7:0]) << (8 * k));
            end
        end
        chk(rd == exp_rd, (!we && nb > 0) ? ((w && sz == 0) ? "R3" : "R6") : tag, rd, exp_rd);
        chk(er == (win == 3 && sz < 2), "R7", 32'(er), 32'(win == 3 && sz < 2));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int idx;
        idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk(!cpu_ready && !cpu_err && !nd_strobe, "R11",
            {29'd0, cpu_ready, cpu_err, nd_strobe}, 32'd0);
        chk(cpu_rdata == 32'd0, "R11", cpu_rdata, 32'd0);
        rst_n = 1'b1;
        for (int n = 0; n < 2; n++)
            for (int w = 0; w < 2; w++)
                for (int win = 0; win < 4; win++)
                    for (int we = 0; we < 2; we++)
                        for (int sz = 0; sz < 4; sz++) begin
                            run_access(n[0], w[0], win, we[0], sz,
                                       32'h8E3D52C7 + 32'(idx) * 32'h09132B05);
                            idx++;
                        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule